// File: doc/BRIEF.md
# Carry-Save Pipelined CORDIC Sine/Cosine Generator

This block turns a signed angle in radians into its cosine and sine. It is an unrolled rotation-mode CORDIC: the angle enters a residual-angle register and a chain of micro-rotation stages follows it. Each stage turns an (x, y) vector by plus or minus atan(2^-i), choosing the direction from the sign of the residual, so that the residual moves toward zero. The vector starts at (1/gain, 0). The final x is then the cosine and the final y is the sine, with no scaling at the output.

The x and y words never pass through a carry-propagate adder inside the chain. Each one travels as a pair of vectors, a partial sum and a carry. Each stage combines the pairs with 3:2 carry-save layers at a fixed word width. The top bit each layer would add is dropped. A single carry-propagate add at the output turns each pair back into two's complement. The residual angle uses ordinary adders, because its sign steers every stage. Registers sit after every stage and after the output adder, and a valid bit moves with the data.

Both edges use valid/ready. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. The whole pipeline moves together. `in_ready` is high whenever the output register is empty or is being drained in that cycle. While a result waits with `out_ready` low, every stage holds its contents.

Top module: `cordic_cs_sincos`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: When `out_ready` stays high, a result appears on `out_valid` exactly STAGES+1 clock edges after its angle was accepted.
- R3: For angles in [-pi/2, pi/2], `out_cos` is within 2^-20 (256 LSB at the default width) of the true cosine.
- R4: For angles in [-pi/2, pi/2], `out_sin` is within 2^-20 of the true sine.
- R5: Every accepted angle produces exactly one result, in the order of acceptance, and no more than STAGES+1 angles are in flight at once.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_valid`, `out_cos` and `out_sin` hold their values on the next edge.
- R7: An angle offered while `in_ready` is 0 is not taken and yields no result.
- R8: The angle is read as signed fixed point with W-3 fraction bits. The outputs are signed fixed point with W-4 fraction bits, so 1.0 is 2^(W-4). The exact corners 0 and plus or minus pi/2 meet the bound of R3 and R4.
- R9: No result appears unless an angle is in flight. With no input, `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An angle is offered |
| in_ready | output | 1 | The pipeline can take an angle this cycle |
| in_angle | input | W | Signed angle in radians, W-3 fraction bits |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_cos | output | W | Signed cosine, W-4 fraction bits |
| out_sin | output | W | Signed sine, W-4 fraction bits |

## Verification
The hardest case to reach from the ports is a redundant pair whose two parts wrap around the word while their true sum stays small. An arithmetic shift of each part then goes wrong unless the pair has been renormalised. This happens most often with large rotations, so the bench drives the exact corners at plus or minus pi/2 and many random angles across the full range, and checks every result against a cosine and sine computed with reals. A second case is a full pipeline that freezes under back-pressure. The bench holds `out_ready` low until it is full, keeps offering new angles that must be refused, and then releases the stall at random to show that nothing is lost or reordered.

// File: rtl/cordic_cs_pkg.sv
package cordic_cs_pkg;

  // Fixed-point code of atan(2^-idx) with frac fraction bits, rounded.
  function automatic longint atan_code(input int idx, input int frac);
    real r;
    r = $atan(1.0 / (2.0 ** idx)) * (2.0 ** frac);
    return longint'(r);
  endfunction

  // Fixed-point code of the reciprocal CORDIC gain after n stages.
  function automatic longint inv_gain_code(input int n, input int frac);
    real p;
    p = 1.0;
    for (int k = 0; k < n; k++) begin
      p = p / $sqrt(1.0 + 1.0 / (2.0 ** (2 * k)));
    end
    return longint'(p * (2.0 ** frac));
  endfunction

endpackage

// File: rtl/cs_adder3.sv
// 3:2 carry-save layer at fixed width; the carry leaving the top bit is dropped.
module cs_adder3 #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-2:0] maj;

  assign sum   = a ^ b ^ c;
  assign maj   = (a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0]);
  assign carry = {maj, cin};
endmodule

// File: rtl/cs_fold.sv
// Renormalises a redundant pair so that neither part wraps relative to the
// pair's true value. The top three bits of both parts are merged into the
// carry part with a 3-bit add. This is valid while |value| < 2^(W-3).
module cs_fold #(
  parameter int W = 32
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  output logic [W-1:0] s_out,
  output logic [W-1:0] c_out
);
  localparam int TOPW = 3;
  logic [TOPW-1:0] top;

  assign top   = s_in[W-1:W-TOPW] + c_in[W-1:W-TOPW];
  assign s_out = {{TOPW{1'b0}}, s_in[W-TOPW-1:0]};
  assign c_out = {top, c_in[W-TOPW-1:0]};
endmodule

// File: rtl/cs_rot_stage.sv
// One registered micro-rotation with x and y kept in carry-save form.
module cs_rot_stage #(
  parameter int             W    = 32,
  parameter int             IDX  = 0,
  parameter logic [W-1:0]   ATAN = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         v_in,
  input  logic [W-1:0] xs_in,
  input  logic [W-1:0] xc_in,
  input  logic [W-1:0] ys_in,
  input  logic [W-1:0] yc_in,
  input  logic [W-1:0] z_in,
  output logic         v_out,
  output logic [W-1:0] xs_out,
  output logic [W-1:0] xc_out,
  output logic [W-1:0] ys_out,
  output logic [W-1:0] yc_out,
  output logic [W-1:0] z_out
);
  logic         turn_pos;
  logic         sub_x, sub_y;
  logic [W-1:0] xn_s, xn_c, yn_s, yn_c;
  logic [W-1:0] xsh_s, xsh_c, ysh_s, ysh_c;
  logic [W-1:0] xm_s, xm_c, ym_s, ym_c;
  logic [W-1:0] x1_s, x1_c, y1_s, y1_c;
  logic [W-1:0] x2_s, x2_c, y2_s, y2_c;
  logic [W-1:0] z_nxt;

  // Non-negative residual turns the vector positively.
  assign turn_pos = ~z_in[W-1];
  assign sub_x    = turn_pos;
  assign sub_y    = ~turn_pos;

  cs_fold #(.W(W)) u_fold_x (.s_in(xs_in), .c_in(xc_in), .s_out(xn_s), .c_out(xn_c));
  cs_fold #(.W(W)) u_fold_y (.s_in(ys_in), .c_in(yc_in), .s_out(yn_s), .c_out(yn_c));

  assign xsh_s = $signed(xn_s) >>> IDX;
  assign xsh_c = $signed(xn_c) >>> IDX;
  assign ysh_s = $signed(yn_s) >>> IDX;
  assign ysh_c = $signed(yn_c) >>> IDX;

  // Negating a pair: invert both parts, +1 injected at each layer's carry LSB.
  assign xm_s = ysh_s ^ {W{sub_x}};
  assign xm_c = ysh_c ^ {W{sub_x}};
  assign ym_s = xsh_s ^ {W{sub_y}};
  assign ym_c = xsh_c ^ {W{sub_y}};

  cs_adder3 #(.W(W)) u_x1 (.a(xn_s), .b(xn_c), .c(xm_s), .cin(sub_x), .sum(x1_s), .carry(x1_c));
  cs_adder3 #(.W(W)) u_x2 (.a(x1_s), .b(x1_c), .c(xm_c), .cin(sub_x), .sum(x2_s), .carry(x2_c));
  cs_adder3 #(.W(W)) u_y1 (.a(yn_s), .b(yn_c), .c(ym_s), .cin(sub_y), .sum(y1_s), .carry(y1_c));
  cs_adder3 #(.W(W)) u_y2 (.a(y1_s), .b(y1_c), .c(ym_c), .cin(sub_y), .sum(y2_s), .carry(y2_c));

  assign z_nxt = turn_pos ? (z_in - ATAN) : (z_in + ATAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
    end else if (en) begin
      v_out <= v_in;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      xs_out <= x2_s;
      xc_out <= x2_c;
      ys_out <= y2_s;
      yc_out <= y2_c;
      z_out  <= z_nxt;
    end
  end
endmodule

// File: rtl/cs_resolve.sv
// Final carry-propagate add of both pairs, registered.
module cs_resolve #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         v_in,
  input  logic [W-1:0] xs_in,
  input  logic [W-1:0] xc_in,
  input  logic [W-1:0] ys_in,
  input  logic [W-1:0] yc_in,
  output logic         v_out,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
    end else if (en) begin
      v_out <= v_in;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      x_out <= xs_in + xc_in;
      y_out <= ys_in + yc_in;
    end
  end
endmodule

// File: rtl/cordic_cs_sincos.sv
module cordic_cs_sincos
  import cordic_cs_pkg::*;
#(
  parameter int W      = 32,
  parameter int STAGES = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_angle,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_cos,
  output logic [W-1:0] out_sin
);
  localparam int           ANG_FRAC = W - 3;
  localparam int           XY_FRAC  = W - 4;
  localparam logic [W-1:0] X_INIT   = W'(inv_gain_code(STAGES, XY_FRAC));

  logic         adv;
  logic         v_q  [0:STAGES];
  logic [W-1:0] xs_q [0:STAGES];
  logic [W-1:0] xc_q [0:STAGES];
  logic [W-1:0] ys_q [0:STAGES];
  logic [W-1:0] yc_q [0:STAGES];
  logic [W-1:0] z_q  [0:STAGES];
  logic         z_unused;

  // Whole pipeline advances when the output slot is empty or being drained.
  assign adv      = out_ready | ~out_valid;
  assign in_ready = adv;

  assign v_q[0]  = in_valid;
  assign xs_q[0] = X_INIT;
  assign xc_q[0] = '0;
  assign ys_q[0] = '0;
  assign yc_q[0] = '0;
  assign z_q[0]  = in_angle;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam logic [W-1:0] ATAN_K = W'(atan_code(k, ANG_FRAC));
    cs_rot_stage #(.W(W), .IDX(k), .ATAN(ATAN_K)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .en    (adv),
      .v_in  (v_q[k]),
      .xs_in (xs_q[k]),
      .xc_in (xc_q[k]),
      .ys_in (ys_q[k]),
      .yc_in (yc_q[k]),
      .z_in  (z_q[k]),
      .v_out (v_q[k+1]),
      .xs_out(xs_q[k+1]),
      .xc_out(xc_q[k+1]),
      .ys_out(ys_q[k+1]),
      .yc_out(yc_q[k+1]),
      .z_out (z_q[k+1])
    );
  end

  assign z_unused = ^z_q[STAGES];

  cs_resolve #(.W(W)) u_resolve (
    .clk  (clk),
    .rst  (rst),
    .en   (adv),
    .v_in (v_q[STAGES]),
    .xs_in(xs_q[STAGES]),
    .xc_in(xc_q[STAGES]),
    .ys_in(ys_q[STAGES]),
    .yc_in(yc_q[STAGES]),
    .v_out(out_valid),
    .x_out(out_cos),
    .y_out(out_sin)
  );
endmodule

// File: rtl/cordic_cs_sincos_chk.sv
module cordic_cs_sincos_chk #(
  parameter int W      = 32,
  parameter int STAGES = 28
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_cos,
  input logic [W-1:0] out_sin
);
  localparam int LAT = STAGES + 1;
  localparam int CW  = $clog2(LAT + 2) + 1;

  logic [CW-1:0] since_rst;
  logic [CW-1:0] inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
    end else if (since_rst < CW'(LAT)) begin
      since_rst <= since_rst + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= '0;
    end else begin
      inflight <= inflight + CW'(in_valid && in_ready) - CW'(out_valid && out_ready);
    end
  end

  // R1 R2
  no_early_result_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CW'(LAT)) |-> !out_valid);

  // R5
  inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LAT));

  // R9
  no_orphan_result_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != '0));

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cos) && $stable(out_sin)));

  // R6
  refuse_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind cordic_cs_sincos cordic_cs_sincos_chk #(.W(W), .STAGES(STAGES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_cos  (out_cos),
  .out_sin  (out_sin)
);

// File: tb/cordic_cs_sincos_tb.sv
module cordic_cs_sincos_tb;
  localparam int     W        = 32;
  localparam int     STAGES   = 28;
  localparam int     LAT      = STAGES + 1;
  localparam int     ANG_FRAC = W - 3;
  localparam int     XY_FRAC  = W - 4;
  localparam longint TOL      = 256;
  localparam real    PI       = 3.14159265358979323846;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] in_angle = '0;
  logic         in_ready, out_valid;
  logic [W-1:0] out_cos, out_sin;

  int     n_checks = 0;
  int     n_fail   = 0;
  bit     done     = 1'b0;
  longint sb [0:4095];
  int     wr = 0;
  int     rd = 0;
  bit     hold = 1'b0;
  logic [W-1:0] held_c, held_s;
  bit     last_ov = 1'b0;
  longint hp_code;

  always #5 clk = ~clk;

  cordic_cs_sincos #(.W(W), .STAGES(STAGES)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_angle(in_angle),
    .out_valid(out_valid), .out_ready(out_ready), .out_cos(out_cos), .out_sin(out_sin)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic check(input string req, input string what, input longint act,
                       input longint exp, input longint tol);
    longint diff;
    n_checks++;
    diff = act - exp;
    if (diff < 0) diff = -diff;
    if (diff > tol) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ang(input real r);
    return W'(longint'(r * (2.0 ** ANG_FRAC)));
  endfunction

  function automatic longint exp_cos(input longint a);
    return longint'($cos(real'(a) / (2.0 ** ANG_FRAC)) * (2.0 ** XY_FRAC));
  endfunction

  function automatic longint exp_sin(input longint a);
    return longint'($sin(real'(a) / (2.0 ** ANG_FRAC)) * (2.0 ** XY_FRAC));
  endfunction

  function automatic logic [W-1:0] rand_ang();
    longint lim;
    lim = hp_code - 1;
    return W'(longint'($urandom_range(32'(2 * lim), 0)) - lim);
  endfunction

  // One cycle: drive at the falling edge, then observe the settled handshake.
  task automatic step(input logic iv, input logic [W-1:0] a, input logic ordy);
    longint ea;
    bit corner;
    @(negedge clk);
    in_valid  = iv;
    in_angle  = a;
    out_ready = ordy;
    #1;
    last_ov = out_valid;
    if (hold) begin
      check("R6", "out_valid held", longint'(out_valid), 1, 0);
      check("R6", "out_cos held", longint'(out_cos), longint'(held_c), 0);
      check("R6", "out_sin held", longint'(out_sin), longint'(held_s), 0);
    end
    if (out_valid && !out_ready) begin
      hold   = 1'b1;
      held_c = out_cos;
      held_s = out_sin;
      check("R6", "in_ready while stalled", longint'(in_ready), 0, 0);
    end else begin
      hold = 1'b0;
    end
    if (in_valid && in_ready) begin
      sb[wr % 4096] = longint'($signed(in_angle));
      wr++;
    end
    if (out_valid && out_ready) begin
      if (rd >= wr) begin
        check("R9", "result with nothing in flight", 1, 0, 0);
      end else begin
        ea     = sb[rd % 4096];
        corner = (ea == 0) || (ea == hp_code) || (ea == -hp_code);
        check(corner ? "R8" : "R3", "cos", longint'($signed(out_cos)), exp_cos(ea), TOL);
        check(corner ? "R8" : "R4", "sin", longint'($signed(out_sin)), exp_sin(ea), TOL);
        rd++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog: actual run not finished, expected finished");
    finish_run();
  end

  initial begin
    int lat;
    bit seen;
    void'($urandom(32'd20240611));
    hp_code = longint'(PI / 2.0 * (2.0 ** ANG_FRAC));

    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", longint'(out_valid), 0, 0);
    check("R1", "in_ready in reset", longint'(in_ready), 1, 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", "out_valid after reset", longint'(out_valid), 0, 0);
    check("R1", "in_ready after reset", longint'(in_ready), 1, 0);

    // R2: latency with the consumer always ready
    step(1'b1, ang(PI / 6.0), 1'b1);
    lat  = 0;
    seen = 1'b0;
    for (int k = 1; k <= LAT + 4; k++) begin
      step(1'b0, '0, 1'b1);
      if (last_ov && !seen) begin
        seen = 1'b1;
        lat  = k;
      end
    end
    check("R2", "latency", longint'(lat), longint'(LAT), 0);

    // R8: corners and directed angles, back to back
    step(1'b1, '0, 1'b1);
    step(1'b1, W'(hp_code), 1'b1);
    step(1'b1, W'(-hp_code), 1'b1);
    step(1'b1, ang(PI / 4.0), 1'b1);
    step(1'b1, ang(-PI / 4.0), 1'b1);
    step(1'b1, W'(1), 1'b1);
    step(1'b1, W'(-1), 1'b1);
    step(1'b1, ang(PI / 3.0), 1'b1);
    step(1'b1, ang(-1.0), 1'b1);

    // R6 R7: fill and freeze; angles offered while in_ready is low must be refused
    for (int k = 0; k < 2 * LAT + 6; k++) begin
      step(1'b1, rand_ang(), 1'b0);
    end
    check("R5", "in flight when frozen", longint'(wr - rd), longint'(LAT), 0);

    // R3 R4 R5: random traffic with random gaps and stalls
    for (int k = 0; k < 1500; k++) begin
      step(($urandom % 4) != 0, rand_ang(), ($urandom % 3) != 0);
    end

    // drain
    for (int k = 0; k < 2 * LAT + 4; k++) begin
      step(1'b0, '0, 1'b1);
    end
    check("R5", "results equal accepted", longint'(rd), longint'(wr), 0);

    // R9: idle input gives no result
    for (int k = 0; k < 8; k++) begin
      step(1'b0, rand_ang(), 1'b1);
      check("R9", "out_valid idle", longint'(out_valid), 0, 0);
    end

    finish_run();
  end
endmodule